// File: doc/BRIEF.md
# Opcode Word Prefetch Unit

This block keeps a 16-bit instruction stream moving into a two-stage pipeline. Three word registers sit in a row. The fetch word is filled from memory. The decode word holds the opcode that the next-instruction decoder examines. The execute word holds the opcode that the datapath is running. Each register has a valid bit. An internal four-step sequencer moves the words forward in a fixed order: the decode word takes the fetch word, a refill read of the fetch word goes out, and then the execute word takes the decode word. One step is left idle, so a base instruction lasts four clocks.

The decode word and the execute word are loaded on different clock edges. For part of every instruction they therefore hold different opcodes: the decoder already sees the next opcode while execution still uses the current one. The fetch word is also available to the datapath as an extension-word source, for example a displacement. Reading it there adds no bus cycle, because the refill read is issued in every instruction whether or not the word is used.

A flush redirects fetching to a new byte address on a control-flow change. It discards the fetch word and the decode word, and the sequence restarts from the fetch fill step.

Top module: `opword_prefetch`

## Requirements
- R1: While reset is high and in the first clock after it, mem_req is 1 with mem_addr equal to RESET_ADDR (default 0x000100), and dec_vld, exe_vld and ext_vld are 0; this fill read is the only one that starts without the sequencer.
- R2: Words move only along fetch word, then decode word, then execute word. The sequence of values on exe_word is the sequence of words returned by memory, in fetch order, with none skipped or repeated.
- R3: The decode word and the execute word never change on the same edge. Each change of exe_word comes exactly 2 clocks after the change of dec_word that supplied it.
- R4: When memory acknowledges within 1 clock of seeing mem_req, exe_word changes every 4 clocks. Over any 16 steady clocks, exe_word changes exactly 4 times and equals dec_word (both valid) in exactly 8 clocks.
- R5: A read keeps mem_req high with mem_addr unchanged until mem_ack. At the acknowledging edge mem_rdata is latched into the fetch word, mem_req drops, and mem_addr advances by 2 bytes.
- R6: At most one read is outstanding. While the sequencer waits for a fetch word, stall is 1 and mem_req is 1. With an acknowledge latency of L clocks (L at least 1), exe_word changes every 4+(L-1) clocks.
- R7: One clock after a flush, dec_vld and ext_vld are 0, mem_req is 1 and mem_addr equals flush_addr. The next word to reach exe_word is the word read from flush_addr.
- R8: No transfer is made from an invalid register. While stall is 1, dec_word holds its value on the next edge. While memory withholds mem_ack, exe_word and dec_word stay unchanged.
- R9: Whenever ext_vld and dec_vld are both 1, ext_word is the word read from the address 2 bytes above the one dec_word was read from.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_req | output | 1 | Read request, held until acknowledged |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_ack | input | 1 | Read acknowledge; data valid in the same clock |
| mem_rdata | input | DATA_W | Read data |
| flush | input | 1 | Redirect fetching and discard the fetch and decode words |
| flush_addr | input | ADDR_W | New fetch byte address, used with flush |
| stall | output | 1 | Sequencer is waiting for a word |
| dec_word | output | DATA_W | Opcode for next-instruction decode |
| dec_vld | output | 1 | dec_word is valid |
| exe_word | output | DATA_W | Opcode now executing |
| exe_vld | output | 1 | exe_word is valid |
| ext_word | output | DATA_W | Fetch word, usable as an extension word |
| ext_vld | output | 1 | ext_word is valid |

## Verification
Every result is counted in edges from the moment it was caused. A word acknowledged at an edge is in ext_word at the next falling-edge sample. It reaches dec_word at the first pull step that follows, and exe_word exactly two edges after that. A flush is visible one edge after it is sampled. The memory model pushes each word it returns into a queue. A monitor samples at the falling edge, pops that queue whenever exe_word changes, and keeps a cycle count so that it can measure the gap between a decode change and an execute change, and between two execute changes. Latency-dependent spacing and the 16-clock equality window are measured only after the pipeline has settled at the chosen latency.

// File: rtl/pf_pkg.sv
package pf_pkg;
  // Steps of the four-clock instruction frame, in the order they run.
  typedef enum logic [1:0] {
    PH_PULL = 2'd0,  // fetch word -> decode word
    PH_FILL = 2'd1,  // start refill read of the fetch word
    PH_EXEC = 2'd2,  // decode word -> execute word
    PH_TAIL = 2'd3   // idle step closing the frame
  } pf_phase_e;

  function automatic pf_phase_e pf_next(input pf_phase_e p);
    case (p)
      PH_PULL: return PH_FILL;
      PH_FILL: return PH_EXEC;
      PH_EXEC: return PH_TAIL;
      default: return PH_PULL;
    endcase
  endfunction
endpackage

// File: rtl/pf_wordreg.sv
module pf_wordreg #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              kill,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  output logic [DATA_W-1:0] word,
  output logic              vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      word <= '0;
      vld  <= 1'b0;
    end else if (kill) begin
      vld  <= 1'b0;
    end else if (load) begin
      word <= load_data;
      vld  <= 1'b1;
    end
  end
endmodule

// File: rtl/pf_fetch.sv
module pf_fetch #(
  parameter int              ADDR_W     = 24,
  parameter int              DATA_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 24'h000100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  input  logic              start,
  input  logic              mem_ack,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              land
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(DATA_W / 8);

  // A read completes when it is acknowledged and no redirect overrides it.
  assign land = mem_req && mem_ack && !flush;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_req  <= 1'b1;          // initial fill, issued only from reset
      mem_addr <= RESET_ADDR;
    end else if (flush) begin
      mem_req  <= 1'b1;
      mem_addr <= flush_addr;
    end else if (land) begin
      mem_req  <= 1'b0;
      mem_addr <= mem_addr + STEP;
    end else if (start && !mem_req) begin
      mem_req  <= 1'b1;
    end
  end
endmodule

// File: rtl/pf_seq.sv
module pf_seq
  import pf_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic flush,
  input  logic src_ok,     // fetch word valid
  input  logic dec_ok,     // decode word valid
  input  logic bus_busy,   // a read is outstanding
  output logic take_dec,
  output logic start_fill,
  output logic take_exe,
  output logic stall
);
  pf_phase_e phase;
  logic      advance;

  always_comb begin
    take_dec   = 1'b0;
    start_fill = 1'b0;
    take_exe   = 1'b0;
    stall      = 1'b0;
    case (phase)
      PH_PULL: begin
        take_dec = src_ok && !flush;
        stall    = !src_ok;
      end
      PH_FILL: begin
        start_fill = !bus_busy && !flush;
        stall      = bus_busy;
      end
      PH_EXEC: begin
        take_exe = dec_ok && !flush;
        stall    = !dec_ok;
      end
      default: ;
    endcase
    advance = (phase == PH_TAIL) || take_dec || start_fill || take_exe;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) phase <= PH_PULL;
    else if (advance) phase <= pf_next(phase);
  end
endmodule

// File: rtl/opword_prefetch.sv
module opword_prefetch #(
  parameter int                ADDR_W     = 24,
  parameter int                DATA_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 24'h000100
) (
  input  logic              clk,
  input  logic              rst,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              flush,
  input  logic [ADDR_W-1:0] flush_addr,
  output logic              stall,
  output logic [DATA_W-1:0] dec_word,
  output logic              dec_vld,
  output logic [DATA_W-1:0] exe_word,
  output logic              exe_vld,
  output logic [DATA_W-1:0] ext_word,
  output logic              ext_vld
);
  localparam int NREG = 3;  // fetch, decode, execute

  logic land, take_dec, start_fill, take_exe;
  logic [NREG-1:0]             r_kill, r_load, r_vld;
  logic [NREG-1:0][DATA_W-1:0] r_in, r_word;

  pf_fetch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_ADDR(RESET_ADDR)) fetch_i (
    .clk(clk), .rst(rst), .flush(flush), .flush_addr(flush_addr),
    .start(start_fill), .mem_ack(mem_ack),
    .mem_req(mem_req), .mem_addr(mem_addr), .land(land)
  );

  pf_seq seq_i (
    .clk(clk), .rst(rst), .flush(flush),
    .src_ok(r_vld[0]), .dec_ok(r_vld[1]), .bus_busy(mem_req),
    .take_dec(take_dec), .start_fill(start_fill), .take_exe(take_exe),
    .stall(stall)
  );

  // Chain wiring: slot 0 is fed by memory, each later slot by the one before.
  assign r_load = {take_exe, take_dec, land};
  assign r_kill = {1'b0, flush, flush || take_dec};
  assign r_in[0] = mem_rdata;

  genvar g;
  generate
    for (g = 1; g < NREG; g++) begin : g_link
      assign r_in[g] = r_word[g-1];
    end
    for (g = 0; g < NREG; g++) begin : g_reg
      pf_wordreg #(.DATA_W(DATA_W)) reg_i (
        .clk(clk), .rst(rst), .kill(r_kill[g]), .load(r_load[g]),
        .load_data(r_in[g]), .word(r_word[g]), .vld(r_vld[g])
      );
    end
  endgenerate

  assign ext_word = r_word[0];
  assign ext_vld  = r_vld[0];
  assign dec_word = r_word[1];
  assign dec_vld  = r_vld[1];
  assign exe_word = r_word[2];
  assign exe_vld  = r_vld[2];
endmodule

// File: rtl/opword_prefetch_chk.sv
module opword_prefetch_chk #(
  parameter int                ADDR_W     = 24,
  parameter int                DATA_W     = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = 24'h000100
) (
  input logic              clk,
  input logic              rst,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack,
  input logic              flush,
  input logic [ADDR_W-1:0] flush_addr,
  input logic              stall,
  input logic [DATA_W-1:0] dec_word,
  input logic              dec_vld,
  input logic [DATA_W-1:0] exe_word,
  input logic              exe_vld,
  input logic              ext_vld
);
  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst) warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  a_r1_reset_fill: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd0) |-> (mem_req && mem_addr == RESET_ADDR && !dec_vld && !exe_vld && !ext_vld));

  a_r5_hold_req: assert property (@(posedge clk) disable iff (rst || warm == 2'd0)
    (mem_req && !mem_ack && !flush) |=> (mem_req && $stable(mem_addr)));

  a_r5_addr_step: assert property (@(posedge clk) disable iff (rst || warm == 2'd0)
    (mem_req && mem_ack && !flush) |=> (!mem_req && mem_addr == $past(mem_addr) + ADDR_W'(2)));

  a_r3_split_edges: assert property (@(posedge clk) disable iff (rst || warm != 2'd3)
    (exe_word != $past(exe_word)) |-> (dec_word == $past(dec_word)));

  a_r8_dec_from_valid: assert property (@(posedge clk) disable iff (rst || warm == 2'd0)
    $rose(dec_vld) |-> $past(ext_vld));

  a_r8_exe_from_valid: assert property (@(posedge clk) disable iff (rst || warm == 2'd0)
    $rose(exe_vld) |-> $past(dec_vld));

  a_r6_stall_waits_bus: assert property (@(posedge clk) disable iff (rst)
    (stall && !flush) |-> mem_req);

  a_r7_flush_redirect: assert property (@(posedge clk) disable iff (rst || warm == 2'd0)
    flush |=> (!dec_vld && !ext_vld && mem_req && mem_addr == $past(flush_addr)));
endmodule

bind opword_prefetch opword_prefetch_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RESET_ADDR(RESET_ADDR)
) chk_i (.*);

// File: tb/opword_prefetch_tb_top.sv
module opword_prefetch_tb_top;
  localparam int          CLK_PERIOD = 10;
  localparam int          AW = 24;
  localparam int          DW = 16;
  localparam logic [AW-1:0] RST_A = 24'h000100;
  localparam logic [DW-1:0] KEY   = 16'hC3A5;

  logic          clk = 0;
  logic          rst = 1;
  logic          mem_req, mem_ack, flush, stall;
  logic [AW-1:0] mem_addr, flush_addr;
  logic [DW-1:0] mem_rdata, dec_word, exe_word, ext_word;
  logic          dec_vld, exe_vld, ext_vld;

  int total = 0, bad = 0;
  int lat = 0;
  logic [AW-1:0] exp_addr = RST_A;
  logic [DW-1:0] exp_q[$];
  int cyc = 0, t_dec = 0, t_exe = 0, gap = 0;
  int win_chg = 0, win_eq = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  opword_prefetch #(.ADDR_W(AW), .DATA_W(DW), .RESET_ADDR(RST_A)) dut_i (
    .clk(clk), .rst(rst), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .flush(flush),
    .flush_addr(flush_addr), .stall(stall), .dec_word(dec_word),
    .dec_vld(dec_vld), .exe_word(exe_word), .exe_vld(exe_vld),
    .ext_word(ext_word), .ext_vld(ext_vld)
  );

  function automatic logic [DW-1:0] word_at(input logic [AW-1:0] a);
    return a[DW-1:0] ^ KEY;
  endfunction

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory model and driver side of the scoreboard: every returned word is expected on exe_word.
  initial begin
    int cnt = 0;
    mem_ack = 0; mem_rdata = '0;
    forever begin
      @(negedge clk);
      if (rst) begin
        mem_ack = 0; cnt = 0;
      end else if (mem_ack) begin
        mem_ack = 0; cnt = 0;
      end else if (mem_req) begin
        if (cnt >= lat) begin
          check(mem_addr == exp_addr, "R5 fetch address", mem_addr, exp_addr);
          mem_rdata = word_at(mem_addr);
          mem_ack = 1;
          exp_q.push_back(word_at(mem_addr));
          exp_addr = exp_addr + 2;
        end else cnt++;
      end
    end
  end

  // Monitor: pops on each execute change; checks spacing, stall hold and extension word.
  initial begin
    logic [DW-1:0] pd = '0, pe = '0;
    logic ps = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst) begin
        if (ps) check(dec_word == pd, "R8 decode word held during stall", dec_word, pd);
        if (dec_vld && dec_word != pd) t_dec = cyc;
        if (exe_vld && exe_word != pe) begin
          logic [DW-1:0] e;
          e = (exp_q.size() > 0) ? exp_q.pop_front() : ~exe_word;
          check(exe_word == e, "R2 execute stream order", exe_word, e);
          check(cyc - t_dec == 2, "R3 decode-to-execute spacing", cyc - t_dec, 2);
          gap = cyc - t_exe;
          t_exe = cyc;
          win_chg++;
        end
        if (dec_vld && exe_vld && dec_word == exe_word) win_eq++;
        if (ext_vld && dec_vld) begin
          logic [DW-1:0] x;
          x = word_at(AW'(dec_word ^ KEY) + 2);
          check(ext_word == x, "R9 extension word follows decode word", ext_word, x);
        end
      end
      pd = dec_word; pe = exe_word; ps = stall && !rst;
    end
  end

  task automatic do_flush(input logic [AW-1:0] a);
    @(negedge clk);
    while (mem_req) @(negedge clk);
    #1;
    exp_q.delete();
    exp_addr = a; flush_addr = a; flush = 1;
    @(negedge clk);
    #1 flush = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [DW-1:0] hold_d, hold_e;
    flush = 0; flush_addr = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(mem_req == 1, "R1 fill request at reset", mem_req, 1);
    check(mem_addr == RST_A, "R1 reset fetch address", mem_addr, RST_A);
    check({dec_vld, exe_vld, ext_vld} == 3'b000, "R1 registers invalid", {dec_vld, exe_vld, ext_vld}, 0);
    rst = 0;
    @(negedge clk); #1;
    check(mem_req == 1 && mem_addr == RST_A, "R1 fill still pending after reset", mem_addr, RST_A);

    // R4 fast memory
    lat = 0;
    repeat (40) @(negedge clk);
    #2; win_chg = 0; win_eq = 0;
    repeat (16) @(negedge clk);
    #2;
    check(win_chg == 4, "R4 execute changes per 16 clocks", win_chg, 4);
    check(win_eq == 8, "R4 matching clocks per 16", win_eq, 8);
    check(gap == 4, "R4 instruction length", gap, 4);
    lat = 1;
    repeat (24) @(negedge clk);
    check(gap == 4, "R4 length with one-clock latency", gap, 4);

    // R6 slow memory
    lat = 5;
    repeat (60) @(negedge clk);
    check(gap == 8, "R6 length with latency 5", gap, 8);
    lat = 3;
    repeat (40) @(negedge clk);
    check(gap == 6, "R6 length with latency 3", gap, 6);

    // R8 memory withholds acknowledge
    lat = 100000;
    repeat (20) @(negedge clk);
    check(stall == 1 && mem_req == 1, "R6 stall while read outstanding", {stall, mem_req}, 3);
    hold_d = dec_word; hold_e = exe_word;
    repeat (30) @(negedge clk);
    check(dec_word == hold_d, "R8 decode word frozen", dec_word, hold_d);
    check(exe_word == hold_e, "R8 execute word frozen", exe_word, hold_e);
    lat = 0;
    repeat (20) @(negedge clk);

    // R7 flush
    do_flush(24'h004000);
    check(!dec_vld && !ext_vld, "R7 decode and fetch words dropped", {dec_vld, ext_vld}, 0);
    check(mem_req && mem_addr == 24'h004000, "R7 redirected fetch", mem_addr, 24'h004000);
    hold_e = exe_word;
    while (exe_word == hold_e) @(negedge clk);
    check(exe_word == word_at(24'h004000), "R7 first executed after flush", exe_word, word_at(24'h004000));
    repeat (30) @(negedge clk);
    do_flush(24'h00A010);
    repeat (40) @(negedge clk);
    check(gap == 4, "R4 length after second flush", gap, 4);
    check(exp_q.size() <= 2, "R2 no words left behind", exp_q.size(), 2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule